// File: doc/BRIEF.md
# Interrupt pin edge-to-message generator

This block watches a bank of level-sensitive interrupt pins and turns each new assertion of a pin into one interrupt message. Every pin has a routing entry, supplied on input ports. The entry carries a mask bit, a vector, a destination, a delivery mode, a destination mode, a polarity bit and a trigger mode bit. When a pin goes high after having been low, the block records the event. If the entry is masked, the event is discarded. The pin's high state is still remembered, so clearing the mask later does not bring the interrupt back.

Recorded events wait as pending bits. They leave one at a time through a valid/ready message port, and the lowest-numbered pin goes first. When an entry selects the external-interrupt delivery mode, the message vector is taken from a vector input driven by a legacy controller instead of from the entry. The block does not resolve destinations and has no register interface.

Top module: `irq_edge_msg`

## Requirements
- R1: After reset, `msg_valid` is low and no pending event survives. Without new pin edges, no message ever appears.
- R2: A pin that goes high while its remembered state is low yields exactly one message if unmasked. The pin staying high yields no further message.
- R3: A pin going low only clears its remembered state and yields no message. A later rise yields a new message.
- R4: A rise on a pin whose mask bit is 1 at that clock edge is dropped. Clearing the mask while the pin stays high produces no message.
- R5: The message destination, delivery mode, destination mode and trigger are copied from the pin's entry. The message level is the entry's polarity bit. The entry is sampled at the edge where the message is loaded.
- R6: If the delivery mode is 3'b111 (external interrupt), `msg_vector` equals `ext_vector` at the load edge. Any other delivery mode (0 fixed, 1 lowest priority, 2 SMI, 4 NMI, 5 INIT) gives the entry's vector.
- R7: Events that are pending together are issued one per accepted message, lowest pin index first.
- R8: While `msg_valid` is high and `msg_ready` is low, the message fields stay stable and no pending event is lost.
- R9: A rise captured at clock edge k makes `msg_valid` high after edge k+1 when the output is idle.
- R10: When a message is accepted and another event is pending, the next message is loaded on the same edge, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Interrupt pin levels |
| rt_mask | input | NUM_PINS | Per-pin mask bit, 1 = masked |
| rt_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W |
| rt_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| rt_dmode | input | NUM_PINS*3 | Per-pin delivery mode |
| rt_destmode | input | NUM_PINS | Per-pin destination mode |
| rt_polarity | input | NUM_PINS | Per-pin polarity bit |
| rt_trigger | input | NUM_PINS | Per-pin trigger mode |
| ext_vector | input | VEC_W | Vector from the legacy controller |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dmode | output | 3 | Message delivery mode |
| msg_destmode | output | 1 | Message destination mode |
| msg_level | output | 1 | Message level |
| msg_trigger | output | 1 | Message trigger mode |

## Verification
Two things can happen in the same clock edge. The output can hand off an accepted message and clear one pending bit. At that same edge, a fresh pin edge can set a pending bit, possibly on the same pin or on a lower-numbered one. The bench provokes this directly by raising a new pin in the very cycle a message is accepted. It also provokes it with a long phase of randomly toggling pins and a random ready signal. A behavioural model, updated at each edge with lists of pin states, compares valid and every field on every clock. This exposes any lost, duplicated or misordered event.

// File: rtl/irq_edge_msg.sv
module irq_edge_msg #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic [NUM_PINS-1:0]        rt_mask,
  input  logic [NUM_PINS*VEC_W-1:0]  rt_vector,
  input  logic [NUM_PINS*DEST_W-1:0] rt_dest,
  input  logic [NUM_PINS*3-1:0]      rt_dmode,
  input  logic [NUM_PINS-1:0]        rt_destmode,
  input  logic [NUM_PINS-1:0]        rt_polarity,
  input  logic [NUM_PINS-1:0]        rt_trigger,
  input  logic [VEC_W-1:0]           ext_vector,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [VEC_W-1:0]           msg_vector,
  output logic [DEST_W-1:0]          msg_dest,
  output logic [2:0]                 msg_dmode,
  output logic                       msg_destmode,
  output logic                       msg_level,
  output logic                       msg_trigger
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [2:0] MODE_EXT = 3'b111;

  logic [NUM_PINS-1:0] pin_seen, pend, new_evt, pend_clr;
  logic [IDX_W-1:0]    sel_idx;
  logic                sel_found, take, load;
  logic [2:0]          sel_mode;

  always_comb begin
    sel_idx   = '0;
    sel_found = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel_idx   = IDX_W'(i);
        sel_found = 1'b1;
      end
    end
  end

  assign new_evt  = pin_i & ~pin_seen & ~rt_mask;
  assign take     = !msg_valid || msg_ready;
  assign load     = take && sel_found;
  assign pend_clr = load ? (NUM_PINS'(1) << sel_idx) : '0;
  assign sel_mode = rt_dmode[sel_idx*3 +: 3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_seen <= '0;
      pend     <= '0;
    end else begin
      pin_seen <= pin_i;
      pend     <= (pend & ~pend_clr) | new_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid    <= 1'b0;
      msg_vector   <= '0;
      msg_dest     <= '0;
      msg_dmode    <= '0;
      msg_destmode <= 1'b0;
      msg_level    <= 1'b0;
      msg_trigger  <= 1'b0;
    end else if (take) begin
      msg_valid <= sel_found;
      if (sel_found) begin
        msg_vector   <= (sel_mode == MODE_EXT) ? ext_vector : rt_vector[sel_idx*VEC_W +: VEC_W];
        msg_dest     <= rt_dest[sel_idx*DEST_W +: DEST_W];
        msg_dmode    <= sel_mode;
        msg_destmode <= rt_destmode[sel_idx];
        msg_level    <= rt_polarity[sel_idx];
        msg_trigger  <= rt_trigger[sel_idx];
      end
    end
  end

  AST_IDLE_WITHOUT_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pend == '0) |=> !msg_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_dmode) && $stable(msg_destmode) && $stable(msg_level)
      && $stable(msg_trigger))); // R8

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
    AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_i[g] && !pin_seen[g] && rt_mask[g] && !pend[g]) |=> !pend[g]); // R4
    AST_HIGH_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_i[g] && pin_seen[g] && !pend[g]) |=> !pend[g]); // R2
    AST_PEND_KEPT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready && pend[g]) |=> pend[g]); // R8
  end
endmodule

// File: tb/test_irq_edge_msg.sv
module test_irq_edge_msg;
  localparam int N = 24;
  localparam int VW = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_i = '0, rt_mask = '0, rt_destmode = '0, rt_polarity = '0, rt_trigger = '0;
  logic [N*VW-1:0] rt_vector = '0;
  logic [N*DW-1:0] rt_dest = '0;
  logic [N*3-1:0]  rt_dmode = '0;
  logic [VW-1:0]   ext_vector = '0;
  logic            msg_ready = 1'b0;
  logic            msg_valid, msg_destmode, msg_level, msg_trigger;
  logic [VW-1:0]   msg_vector;
  logic [DW-1:0]   msg_dest;
  logic [2:0]      msg_dmode;

  irq_edge_msg #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW)) i_irq_edge_msg (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rt_mask(rt_mask), .rt_vector(rt_vector),
    .rt_dest(rt_dest), .rt_dmode(rt_dmode), .rt_destmode(rt_destmode),
    .rt_polarity(rt_polarity), .rt_trigger(rt_trigger), .ext_vector(ext_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_dmode(msg_dmode), .msg_destmode(msg_destmode),
    .msg_level(msg_level), .msg_trigger(msg_trigger));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit m_seen[N], m_pend[N];
  bit m_valid;
  int m_vec, m_dest, m_mode, m_dm, m_lvl, m_trg;
  int acc_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_seen[i]) begin m_seen[i] = 0; m_pend[i] = 0; end
      m_valid = 0;
    end else begin
      if (msg_valid && msg_ready) acc_q.push_back(int'(msg_dest));
      if (!m_valid || msg_ready) begin
        int pick;
        pick = -1;
        for (int i = 0; i < N; i++) if (m_pend[i] && pick < 0) pick = i;
        m_valid = (pick >= 0);
        if (pick >= 0) begin
          m_pend[pick] = 0;
          m_mode = int'(rt_dmode[pick*3 +: 3]);
          m_vec  = (m_mode == 7) ? int'(ext_vector) : int'(rt_vector[pick*VW +: VW]);
          m_dest = int'(rt_dest[pick*DW +: DW]);
          m_dm   = int'(rt_destmode[pick]);
          m_lvl  = int'(rt_polarity[pick]);
          m_trg  = int'(rt_trigger[pick]);
        end
      end
      for (int i = 0; i < N; i++) begin
        if (pin_i[i] && !m_seen[i] && !rt_mask[i]) m_pend[i] = 1;
        m_seen[i] = pin_i[i];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_n) begin
        chk({cur_req, " valid"}, int'(msg_valid), int'(m_valid));
        if (m_valid) begin
          chk({cur_req, " vector"}, int'(msg_vector), m_vec);
          chk({cur_req, " dest"}, int'(msg_dest), m_dest);
          chk({cur_req, " dmode"}, int'(msg_dmode), m_mode);
          chk({cur_req, " destmode"}, int'(msg_destmode), m_dm);
          chk({cur_req, " level"}, int'(msg_level), m_lvl);
          chk({cur_req, " trigger"}, int'(msg_trigger), m_trg);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      rt_vector[i*VW +: VW] = VW'(8'h20 + i);
      rt_dest[i*DW +: DW]   = DW'(8'h40 + i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    cyc(1);
    chk("R1 valid after reset", int'(msg_valid), 0);
    cyc(5);

    cur_req = "R9"; msg_ready = 1'b1;
    pin_i[3] = 1'b1;
    cyc(1); chk("R9 not yet valid", int'(msg_valid), 0);
    cyc(1); chk("R9 valid after two edges", int'(msg_valid), 1);
    cur_req = "R2"; acc_q.delete();
    cyc(10);
    chk("R2 one message while held high", acc_q.size(), 1);

    cur_req = "R3"; acc_q.delete();
    pin_i[3] = 1'b0; cyc(5);
    chk("R3 no message on fall", acc_q.size(), 0);
    pin_i[3] = 1'b1; cyc(5);
    chk("R3 new message on re-rise", acc_q.size(), 1);

    cur_req = "R4"; acc_q.delete();
    rt_mask[5] = 1'b1; pin_i[5] = 1'b1; cyc(4);
    rt_mask[5] = 1'b0; cyc(6);
    chk("R4 unmask does not replay", acc_q.size(), 0);
    pin_i[5] = 1'b0; cyc(2); pin_i[5] = 1'b1; cyc(5);
    chk("R4 later rise after unmask", acc_q.size(), 1);

    cur_req = "R5";
    rt_dmode[8*3 +: 3] = 3'd1; rt_destmode[8] = 1'b1; rt_polarity[8] = 1'b1; rt_trigger[8] = 1'b1;
    msg_ready = 1'b0; pin_i[8] = 1'b1; cyc(3);
    chk("R5 level from polarity", int'(msg_level), 1);
    chk("R5 dest copied", int'(msg_dest), 8'h48);
    msg_ready = 1'b1; cyc(2);

    cur_req = "R6";
    rt_dmode[7*3 +: 3] = 3'd7; ext_vector = 8'hA5;
    msg_ready = 1'b0; pin_i[7] = 1'b1; cyc(1); ext_vector = 8'h5C; cyc(2);
    chk("R6 external vector at load", int'(msg_vector), 8'h5C);
    msg_ready = 1'b1; cyc(2);
    rt_dmode[7*3 +: 3] = 3'd4; pin_i[7] = 1'b0; cyc(2); pin_i[7] = 1'b1; cyc(3);

    cur_req = "R7"; acc_q.delete(); msg_ready = 1'b0;
    pin_i[9] = 1'b1; pin_i[2] = 1'b1; pin_i[4] = 1'b1;
    cur_req = "R8"; cyc(6);
    cur_req = "R7"; msg_ready = 1'b1; cyc(6);
    chk("R7 count", acc_q.size(), 3);
    if (acc_q.size() == 3) begin
      chk("R7 first", acc_q[0], 8'h42);
      chk("R7 second", acc_q[1], 8'h44);
      chk("R7 third", acc_q[2], 8'h49);
    end

    cur_req = "R10"; pin_i = '0; cyc(3);
    msg_ready = 1'b0; pin_i[1] = 1'b1; pin_i[0] = 1'b1; pin_i[11] = 1'b1; cyc(3);
    msg_ready = 1'b1; cyc(1);
    chk("R10 no bubble", int'(msg_valid), 1);
    pin_i[6] = 1'b1; cyc(1);
    chk("R10 still valid", int'(msg_valid), 1);
    cyc(6);

    cur_req = "R2";
    for (int t = 0; t < 3000; t++) begin
      pin_i = pin_i ^ (N'($urandom) & N'($urandom) & N'($urandom));
      msg_ready = 1'($urandom);
      if (t % 50 == 0) begin
        rt_mask = N'($urandom) & N'($urandom);
        rt_polarity = N'($urandom);
        rt_trigger = N'($urandom);
        for (int i = 0; i < N; i++) rt_dmode[i*3 +: 3] = 3'($urandom);
      end
      ext_vector = VW'($urandom);
      cyc(1);
    end
    msg_ready = 1'b1; cyc(40);
    chk("R1 drained idle", int'(msg_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule